// File: doc/BRIEF.md
# Dual-Channel Multi-Mode Timer

This block pairs two 16-bit down-counters with their own reload registers, a duty compare register, two capture registers and one PWM output. A two-bit mode field chooses how the pair is used. It can generate a free-running pulse train without processor help. It can time-stamp events on two external inputs. It can run two separate timers, each paced by the clock-enable or by edges on its external input. It can also run one capture channel beside one timer or event counter.

Both external inputs pass through a two-flop synchronizer and an edge selector (none, rising, falling or both). Status flags cover counter wrap, capture and capture overrun. Software clears them by writing ones. The register port accepts a write on every cycle it is enabled and never pushes back. Reads are combinational from a separate read address. A single clock-enable input (`tick_en`) stands in for an external prescaler.

Register addresses: 0 control, 1 reload 0, 2 reload 1, 3 duty compare, 4 counter 0, 5 counter 1, 6 capture 0, 7 capture 1, 8 status. Control bits: [1:0] mode (0 PWM, 1 dual capture, 2 dual timer, 3 capture plus timer), [2] run 0, [3] run 1, [4] source 0, [5] source 1 (1 = count input edges), [7:6] edge select for input 0, [9:8] edge select for input 1 (00 none, 01 rising, 10 falling, 11 both). Status bits: [1:0] wrap, [3:2] capture, [5:4] overrun.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, every register, the counters, the status flags and `pwm_out` read zero.
- R2: A running counter steps down by one per enable. From zero it loads its reload value and sets its wrap flag (status bit 0 or 1). A write to a reload register also loads that counter at once.
- R3: In mode 0 with run 0 set, `pwm_out` is the registered result of counter 0 greater than the compare value. Over one period of reload+1 enables it is high for reload minus compare cycles, or for none when compare is not below reload. In any other mode, or with run 0 clear, it is low.
- R4: Each input is synchronized by two flops. The edge select acts as none (00), rising (01), falling (10) or both (11). A capture or event count lands on the third clock edge after the input changes.
- R5: In mode 1, a selected edge on input 0 copies counter 0 into capture 0. A selected edge on input 1 copies counter 1 into capture 1. Each sets its capture flag (status bit 2 or 3).
- R6: A capture that arrives while its flag is still set overwrites the value and sets the overrun flag (status bit 4 or 5).
- R7: Writing ones to the status register clears those flags. A capture in the same cycle as the clear of its flag leaves the flag set and does not set overrun.
- R8: In mode 2, a counter whose source bit is set steps once per selected edge of its own input. A counter whose source bit is clear steps on `tick_en`. No capture flag is set in this mode.
- R9: In mode 3, input 0 captures counter 0. Channel 1 never captures, and counter 1 is paced by `tick_en` or by edges of input 1 according to source 1.
- R10: With `tick_en` low, tick-paced counters hold their value. Edge-paced counters step whatever `tick_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Count enable for tick-paced counters |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Read data, combinational |
| ev_in | input | 2 | External event inputs, asynchronous |
| pwm_out | output | 1 | PWM waveform |
| und_flag | output | 2 | Counter wrap flags |
| cap_flag | output | 2 | Capture flags |
| ovf_flag | output | 2 | Capture overrun flags |

## Verification
A capture on a channel and a software clear of the same channel's capture flag can land on one clock edge. The bench raises the input, waits two cycles for the synchronizer, and times the status write so that it commits on the edge where the capture is taken. It then expects the capture flag still set and the overrun flag clear. The same pending-flag path is also driven without a clear, where overrun must appear and the capture register must hold the newer value.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

  typedef enum logic [1:0] {
    MODE_PWM  = 2'd0,
    MODE_DCAP = 2'd1,
    MODE_DTMR = 2'd2,
    MODE_CAPT = 2'd3
  } mode_e;

  typedef struct packed {
    logic [1:0] sel_b;
    logic [1:0] sel_a;
    logic       src1;
    logic       src0;
    logic       run1;
    logic       run0;
    mode_e      mode;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_RLD0 = 4'd1;
  localparam logic [3:0] A_RLD1 = 4'd2;
  localparam logic [3:0] A_CMP  = 4'd3;
  localparam logic [3:0] A_CNT0 = 4'd4;
  localparam logic [3:0] A_CNT1 = 4'd5;
  localparam logic [3:0] A_CAP0 = 4'd6;
  localparam logic [3:0] A_CAP1 = 4'd7;
  localparam logic [3:0] A_STAT = 4'd8;

endpackage

// File: rtl/dmt_edge.sv
module dmt_edge #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit
);
  logic [SYNC-1:0] sh_q;
  logic            prev_q;
  logic            s;
  logic            rise, fall;

  assign s = sh_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[SYNC-2:0], din};
      prev_q <= s;
    end
  end

  assign rise = s & ~prev_q;
  assign fall = ~s & prev_q;

  always_comb begin
    case (sel)
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      2'b11:   hit = rise | fall;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  assign wrap = en && !load && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (en) begin
      if (cnt == '0)     cnt <= reload;
      else               cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dmt_capture.sv
module dmt_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] value,
  input  logic         clr_cap,
  input  logic         clr_ovf,
  output logic [W-1:0] cap_val,
  output logic         cap_flag,
  output logic         ovf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val  <= '0;
      cap_flag <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      if (evt) cap_val <= value;

      if (evt)          cap_flag <= 1'b1;
      else if (clr_cap) cap_flag <= 1'b0;

      if (evt && cap_flag && !clr_cap) ovf_flag <= 1'b1;
      else if (clr_ovf)                ovf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
#(
  parameter int W    = 16,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic [1:0]    ev_in,
  output logic          pwm_out,
  output logic [1:0]    und_flag,
  output logic [1:0]    cap_flag,
  output logic [1:0]    ovf_flag
);
  localparam int NCH = 2;

  ctrl_t                   ctrl_q;
  logic [NCH-1:0][W-1:0]   rld_q;
  logic [W-1:0]            cmp_q;
  logic [NCH-1:0][W-1:0]   cnt;
  logic [NCH-1:0][W-1:0]   cap_val;
  logic [NCH-1:0][1:0]     sel;
  logic [NCH-1:0]          hit, cnt_en, wrap, load, cap_evt, run, src;
  logic [NCH-1:0]          clr_und, clr_cap, clr_ovf;
  logic [NCH-1:0]          und_q;
  logic                    wr_stat;
  logic                    pwm_q;

  assign sel[0] = ctrl_q.sel_a;
  assign sel[1] = ctrl_q.sel_b;
  assign run    = {ctrl_q.run1, ctrl_q.run0};
  assign src    = {ctrl_q.src1, ctrl_q.src0};

  // register writes
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign clr_und = wr_stat ? wr_data[1:0] : '0;
  assign clr_cap = wr_stat ? wr_data[3:2] : '0;
  assign clr_ovf = wr_stat ? wr_data[5:4] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rld_q  <= '0;
      cmp_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_addr == A_CMP)  cmp_q  <= wr_data;
      for (int i = 0; i < NCH; i++)
        if (wr_addr == AW'(A_RLD0 + i)) rld_q[i] <= wr_data;
    end
  end

  // mode dependent pacing and capture gating
  always_comb begin
    cnt_en  = '0;
    cap_evt = '0;
    unique case (ctrl_q.mode)
      MODE_PWM: begin
        cnt_en[0] = run[0] & tick_en;
      end
      MODE_DCAP: begin
        cnt_en  = run & {NCH{tick_en}};
        cap_evt = hit;
      end
      MODE_DTMR: begin
        for (int i = 0; i < NCH; i++)
          cnt_en[i] = run[i] & (src[i] ? hit[i] : tick_en);
      end
      MODE_CAPT: begin
        cnt_en[0]  = run[0] & tick_en;
        cnt_en[1]  = run[1] & (src[1] ? hit[1] : tick_en);
        cap_evt[0] = hit[0];
      end
      default: ;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign load[g] = wr_en && (wr_addr == AW'(A_RLD0 + g));

      dmt_edge #(.SYNC(SYNC)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(ev_in[g]), .sel(sel[g]), .hit(hit[g])
      );

      dmt_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load[g]), .load_val(wr_data),
        .en(cnt_en[g]), .reload(rld_q[g]), .cnt(cnt[g]), .wrap(wrap[g])
      );

      dmt_capture #(.W(W)) u_cap (
        .clk(clk), .rst_n(rst_n), .evt(cap_evt[g]), .value(cnt[g]),
        .clr_cap(clr_cap[g]), .clr_ovf(clr_ovf[g]),
        .cap_val(cap_val[g]), .cap_flag(cap_flag[g]), .ovf_flag(ovf_flag[g])
      );

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          und_q[g] <= 1'b0;
        else if (wrap[g])    und_q[g] <= 1'b1;
        else if (clr_und[g]) und_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign und_flag = und_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= (ctrl_q.mode == MODE_PWM) && ctrl_q.run0 && (cnt[0] > cmp_q);
  end
  assign pwm_out = pwm_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data = W'(ctrl_q);
      A_RLD0: rd_data = rld_q[0];
      A_RLD1: rd_data = rld_q[1];
      A_CMP:  rd_data = cmp_q;
      A_CNT0: rd_data = cnt[0];
      A_CNT1: rd_data = cnt[1];
      A_CAP0: rd_data = cap_val[0];
      A_CAP1: rd_data = cap_val[1];
      A_STAT: rd_data = W'({ovf_flag, cap_flag, und_q});
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dmt_checks.sv
module dmt_checks #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         pwm_out,
  input logic [1:0]   wrap,
  input logic [1:0]   und_flag,
  input logic [1:0]   cap_evt,
  input logic [1:0]   cap_flag,
  input logic [1:0]   ovf_flag,
  input logic [1:0]   clr_cap,
  input logic         en0,
  input logic         load0,
  input logic [W-1:0] cnt0,
  input logic [W-1:0] rld0,
  input logic [W-1:0] cap0
);
  p_pwm_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> !pwm_out);

  p_wrap_flag0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[0] |=> und_flag[0]);

  p_wrap_flag1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap[1] |=> und_flag[1]);

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 && !load0 && cnt0 == '0) |=> (cnt0 == $past(rld0)));

  p_cap_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[0] |=> (cap0 == $past(cnt0)));

  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt[0] && cap_flag[0] && !clr_cap[0]) |=> ovf_flag[0]);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[0] |=> cap_flag[0]);

  p_no_cap1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd1) |-> !cap_evt[1]);
endmodule

bind dual_mode_timer dmt_checks #(.W(W)) u_checks (
  .clk(clk), .rst_n(rst_n), .mode(ctrl_q.mode), .pwm_out(pwm_out),
  .wrap(wrap), .und_flag(und_flag), .cap_evt(cap_evt), .cap_flag(cap_flag),
  .ovf_flag(ovf_flag), .clr_cap(clr_cap), .en0(cnt_en[0]), .load0(load[0]),
  .cnt0(cnt[0]), .rld0(rld_q[0]), .cap0(cap_val[0])
);

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [1:0]  ev_in = '0;
  logic        pwm_out;
  logic [1:0]  und_flag, cap_flag, ovf_flag;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_mode_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in),
    .pwm_out(pwm_out), .und_flag(und_flag), .cap_flag(cap_flag), .ovf_flag(ovf_flag)
  );

  function automatic logic [15:0] mk_ctrl(int md, bit r0, bit r1, bit s0, bit s1,
                                          int ea, int eb);
    return 16'(md) | (16'(r0) << 2) | (16'(r1) << 3) | (16'(s0) << 4) |
           (16'(s1) << 5) | (16'(ea) << 6) | (16'(eb) << 8);
  endfunction

  function automatic int exp_high(int rld, int cmp);
    return (rld > cmp) ? rld - cmp : 0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse(int ch);
    @(negedge clk);
    ev_in[ch] = 1'b1;
    repeat (4) @(negedge clk);
    ev_in[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, v); check("R1 ctrl", v, 0);
    rd(4'd4, v); check("R1 cnt0", v, 0);
    rd(4'd8, v); check("R1 status", v, 0);
    check("R1 pwm", pwm_out, 0);

    // R2 / R10 down count, reload, wrap flag
    wr(4'd0, mk_ctrl(2, 1, 0, 0, 0, 0, 0));
    wr(4'd1, 16'd5);
    rd(4'd4, v); check("R2 load on reload write", v, 5);
    repeat (4) @(negedge clk);
    rd(4'd4, v); check("R10 hold without tick", v, 5);
    ticks(3);
    rd(4'd4, v); check("R2 down count", v, 2);
    ticks(3);
    rd(4'd4, v); check("R2 reload after zero", v, 5);
    rd(4'd8, v); check("R2 wrap flag", v & 16'h3, 1);
    wr(4'd8, 16'h0001);
    rd(4'd8, v); check("R7 clear wrap", v, 0);

    // R8 / R4 / R10 event counting on input 1
    wr(4'd0, mk_ctrl(2, 0, 1, 0, 1, 0, 1));
    wr(4'd2, 16'd10);
    tick_en = 1'b1;
    repeat (3) pulse(1);
    tick_en = 1'b0;
    rd(4'd5, v); check("R8 rising edges counted, R10 tick ignored", v, 7);
    wr(4'd0, mk_ctrl(2, 0, 1, 0, 1, 0, 3));
    repeat (2) pulse(1);
    rd(4'd5, v); check("R4 both edges", v, 3);
    wr(4'd0, mk_ctrl(2, 0, 1, 0, 1, 0, 2));
    pulse(1);
    rd(4'd5, v); check("R4 falling only", v, 2);
    wr(4'd0, mk_ctrl(2, 0, 1, 0, 1, 0, 0));
    pulse(1);
    rd(4'd5, v); check("R4 select none", v, 2);
    rd(4'd8, v); check("R8 no capture flags", v & 16'h3C, 0);

    // R3 PWM duty, constrained random
    wr(4'd0, mk_ctrl(0, 1, 0, 0, 0, 0, 0));
    for (int it = 0; it < 8; it++) begin
      int rl, cp, hi;
      rl = $urandom_range(3, 40);
      cp = (it == 0) ? rl : (it == 1) ? 0 : $urandom_range(0, 45);
      wr(4'd3, 16'(cp));
      wr(4'd1, 16'(rl));
      @(negedge clk); tick_en = 1'b1;
      repeat (rl + 4) @(negedge clk);
      hi = 0;
      for (int k = 0; k <= rl; k++) begin
        if (pwm_out) hi++;
        @(negedge clk);
      end
      check("R3 high cycles per period", hi, exp_high(rl, cp));
    end
    wr(4'd0, mk_ctrl(1, 1, 0, 0, 0, 0, 0));
    repeat (2) @(negedge clk);
    check("R3 low outside PWM mode", pwm_out, 0);
    tick_en = 1'b0;

    // R5 dual capture
    wr(4'd8, 16'h003F);
    wr(4'd0, mk_ctrl(1, 1, 1, 0, 0, 1, 2));
    wr(4'd1, 16'h1234);
    wr(4'd2, 16'h0ABC);
    pulse(0);
    rd(4'd6, v); check("R5 capture 0 value", v, 16'h1234);
    rd(4'd8, v); check("R5 capture 0 flag", v, 16'h0004);
    @(negedge clk); ev_in[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd(4'd8, v); check("R4 rising ignored on falling select", v, 16'h0004);
    ev_in[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(4'd7, v); check("R5 capture 1 value", v, 16'h0ABC);
    rd(4'd8, v); check("R5 capture 1 flag", v, 16'h000C);

    // R6 overrun
    wr(4'd1, 16'h2222);
    pulse(0);
    rd(4'd6, v); check("R6 newer value kept", v, 16'h2222);
    rd(4'd8, v); check("R6 overrun flag", v & 16'h30, 16'h10);
    wr(4'd8, 16'h003F);
    rd(4'd8, v); check("R7 clear all", v, 0);

    // R7 clear and capture on the same edge
    pulse(0);
    @(negedge clk); ev_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 4'd8; wr_data = 16'h0004;
    @(negedge clk); wr_en = 1'b0;
    rd(4'd8, v); check("R7 set wins over clear, no overrun", v, 16'h0004);
    @(negedge clk); ev_in[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R9 combined mode
    wr(4'd8, 16'h003F);
    wr(4'd0, mk_ctrl(3, 1, 1, 0, 0, 1, 1));
    wr(4'd1, 16'h0055);
    wr(4'd2, 16'd9);
    pulse(1);
    rd(4'd8, v); check("R9 channel 1 no capture", v, 0);
    rd(4'd7, v); check("R9 capture 1 unchanged", v, 16'h0ABC);
    rd(4'd5, v); check("R9 tick paced counter 1 ignores edge", v, 9);
    pulse(0);
    rd(4'd6, v); check("R9 capture 0 value", v, 16'h0055);
    wr(4'd0, mk_ctrl(3, 1, 1, 0, 1, 1, 1));
    pulse(1);
    rd(4'd5, v); check("R9 edge paced counter 1", v, 8);

    // R5 random capture values
    wr(4'd0, mk_ctrl(1, 1, 1, 0, 0, 3, 0));
    for (int it = 0; it < 6; it++) begin
      logic [15:0] r;
      r = 16'($urandom);
      wr(4'd1, r);
      pulse(0);
      rd(4'd6, v); check("R5 random capture", v, r);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule